// File: doc/BRIEF.md
# Buffered Serial Receiver with Address Filtering

This block is the receiving side of a small microcontroller-style serial port. It turns a serial line into bytes in one of four modes. Mode 0 is a synchronous shift mode: the block drives its own shift clock and reads eight bits. Mode 1 takes 10-bit asynchronous frames. Modes 2 and 3 take 11-bit asynchronous frames that carry a ninth bit; the two differ only in bit rate, and the bit rate comes from outside. Bit-rate timing enters as two strobes. One strobe runs at sixteen times the asynchronous bit rate. The other paces the synchronous shift clock.

A completed byte is copied from the shift register into a separate holding register, together with one status bit. That bit holds the stop bit in mode 1 and the ninth bit in modes 2 and 3. Copying the byte raises a done flag that the host clears. The host can set a filter bit so that only address frames are reported: in modes 2 and 3 the ninth bit must be 1, and in mode 1 the stop bit must be valid. A frame that the filter rejects leaves the holding register unchanged. A frame that completes while the flag is still set is dropped.

Top module: `serial_rx_filtered`

## Requirements
- R1: After reset the done flag is 0, the held byte is 0x00, the status bit is 0 and the shift clock output is 1.
- R2: The mode field selects the frame format: 0 is synchronous shift, 1 is a 10-bit frame, and 2 and 3 are 11-bit frames. In modes 1 to 3 a frame starts on a low line seen at an oversampling strobe while the receive enable is 1. With the enable at 0 no frame is taken.
- R3: In the asynchronous modes each bit is the majority of oversamples 7, 8 and 9, counted from the strobe that saw the start. A start bit that votes 1 returns the receiver to idle without reporting anything.
- R4: Eight data bits arrive least significant bit first and appear as the held byte.
- R5: In mode 1 the stop bit is stored as the status bit. With the filter bit set, a frame with a stop bit of 0 does not raise the flag.
- R6: In modes 2 and 3 the ninth bit is stored as the status bit and the stop bit is ignored. With the filter bit set, only frames whose ninth bit is 1 raise the flag.
- R7: A frame rejected by the filter updates neither the held byte nor the status bit.
- R8: A frame that completes while the done flag is 1 (and is not cleared in that cycle) is discarded, and the old byte, status bit and flag are kept.
- R9: A one-cycle clear pulse lowers the flag. A clear in the same cycle as an accepted frame counts as a read: the new byte is taken and the flag stays 1.
- R10: Mode 0 starts only while the enable is 1 and the flag is 0. Each bit is one low and one high phase of the shift clock, each phase one pacing strobe long, and the line is sampled as the clock rises. The status bit is written as 0, and the filter bit has no effect.
- R11: A new frame may shift in while the flag is still 1. If the host clears the flag before that frame completes, the frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | Frame mode 0 to 3 |
| mp_en | input | 1 | Address-filter control bit |
| done_clr | input | 1 | One-cycle pulse that clears the done flag |
| os_tick | input | 1 | Strobe at 16 times the asynchronous bit rate |
| m0_tick | input | 1 | Strobe that paces each shift clock phase in mode 0 |
| rxd | input | 1 | Serial data line |
| shift_clk | output | 1 | Shift clock driven in mode 0, high otherwise |
| rx_byte | output | 8 | Held received byte |
| rx_bit9 | output | 1 | Held ninth-bit or stop-bit status |
| rx_done | output | 1 | Receive-done flag |

## Verification
The host clear and the completion of a frame can fall in the same clock cycle, and the block then has to treat the clear as a read and keep the new byte. The bench first sends a reference frame with the flag low and records the cycle in which the flag rises. It then sends a second frame with the same strobe alignment and places a one-cycle clear exactly on that completion edge. The result is judged by the flag staying 1 and the held byte being the second frame's value; a receiver that wrongly drops the frame shows the flag low and the first byte instead.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam logic [1:0] MODE_SHIFT = 2'd0;
  localparam logic [1:0] MODE_ASYNC10 = 2'd1;

  // 2-of-3 majority of the three mid-bit samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // index of the last bit slot of a frame: start=0, data 1..dw, then ninth/stop
  function automatic int frame_last(input logic nine, input int dw);
    return dw + (nine ? 2 : 1);
  endfunction

  // whether a completed frame may raise the done flag
  function automatic logic report_ok(input logic [1:0] md, input logic filt,
                                     input logic b9);
    if (md == MODE_SHIFT) return 1'b1;
    return !filt || b9;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_async_frame.sv
module rx_async_frame
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic          nine_bit,
  input  logic          tick,
  input  logic          line,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          busy
);
  localparam int SCW = $clog2(OVS);
  localparam int BIW = $clog2(DW + 3);
  localparam logic [SCW-1:0] DECIDE = SCW'(OVS / 2 + 1);

  logic [SCW-1:0] sc;
  logic [BIW-1:0] bi;
  logic [1:0]     hist;
  logic [BIW-1:0] last_bi;
  logic           mid_pt;
  logic           vote_v;

  assign last_bi = BIW'(frame_last(nine_bit, DW));
  assign mid_pt  = tick && busy && (sc == DECIDE);
  assign vote_v  = vote3(hist[1], hist[0], line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sc   <= '0;
      bi   <= '0;
      hist <= 2'b11;
      data <= '0;
      bit9 <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (!busy) begin
          if (start_ok && !line) begin
            busy <= 1'b1;
            sc   <= SCW'(1);
            bi   <= '0;
          end
        end else begin
          hist <= {hist[0], line};
          sc   <= sc + 1'b1;
          if (sc == DECIDE) begin
            if (bi == '0) begin
              if (vote_v) busy <= 1'b0;
            end else if (bi <= BIW'(DW)) begin
              data <= {vote_v, data[DW-1:1]};
            end else if (bi == BIW'(DW + 1)) begin
              bit9 <= vote_v;
            end
            if (bi == last_bi) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
            bi <= bi + 1'b1;
          end
        end
      end
    end
  end

  p_glitch_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_pt && bi == '0 && vote_v) |=> !busy);
  p_done_at_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mid_pt));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/rx_shift_frame.sv
module rx_shift_frame #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic          tick,
  input  logic          line,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          sclk,
  output logic          busy
);
  localparam int CW = $clog2(DW);

  logic [CW-1:0] cnt;
  logic          phase;
  logic          rise_ev;

  assign rise_ev = busy && tick && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= 1'b0;
      cnt   <= '0;
      data  <= '0;
      sclk  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start_ok) begin
          busy  <= 1'b1;
          phase <= 1'b0;
          cnt   <= '0;
        end
      end else if (tick) begin
        if (!phase) begin
          sclk  <= 1'b0;
          phase <= 1'b1;
        end else begin
          sclk  <= 1'b1;
          phase <= 1'b0;
          data  <= {line, data[DW-1:1]};
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(DW - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);
  p_sample_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> sclk);
endmodule

// File: rtl/rx_holding.sv
module rx_holding
  import serial_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_data,
  input  logic          frame_b9,
  input  logic [1:0]    mode,
  input  logic          mp_en,
  input  logic          clr,
  output logic [DW-1:0] hold_data,
  output logic          hold_b9,
  output logic          flag
);
  logic gate;
  logic accept;

  assign gate   = report_ok(mode, mp_en, frame_b9);
  assign accept = frame_done && gate && (!flag || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_b9   <= 1'b0;
      flag      <= 1'b0;
    end else begin
      if (accept) begin
        hold_data <= frame_data;
        hold_b9   <= frame_b9;
        flag      <= 1'b1;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  p_suppress_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !gate) |=> ($stable(hold_data) && $stable(hold_b9)));
  p_overrun_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && flag && !clr) |=> ($stable(hold_data) && flag));
  p_clear_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !accept) |=> !flag);
  p_accept_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> flag);
endmodule

// File: rtl/serial_rx_filtered.sv
module serial_rx_filtered
  import serial_rx_pkg::*;
#(
  parameter int DW        = 8,
  parameter int OVS       = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic [1:0]    mode,
  input  logic          mp_en,
  input  logic          done_clr,
  input  logic          os_tick,
  input  logic          m0_tick,
  input  logic          rxd,
  output logic          shift_clk,
  output logic [DW-1:0] rx_byte,
  output logic          rx_bit9,
  output logic          rx_done
);
  logic          line_s;
  logic          is_shift;
  logic          a_start, s_start;
  logic          a_done, s_done, a_b9, a_busy, s_busy;
  logic [DW-1:0] a_data, s_data;
  logic          f_done, f_b9;
  logic [DW-1:0] f_data;

  assign is_shift = (mode == MODE_SHIFT);
  assign a_start  = !is_shift && rx_en;
  assign s_start  = is_shift && rx_en && !rx_done && !s_done;

  rx_line_sync #(.STAGES(SYNC_STGS)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s));

  rx_async_frame #(.OVS(OVS), .DW(DW)) i_async (
    .clk(clk), .rst_n(rst_n), .start_ok(a_start), .nine_bit(mode[1]),
    .tick(os_tick), .line(line_s), .done(a_done), .data(a_data),
    .bit9(a_b9), .busy(a_busy));

  rx_shift_frame #(.DW(DW)) i_shift (
    .clk(clk), .rst_n(rst_n), .start_ok(s_start), .tick(m0_tick),
    .line(line_s), .done(s_done), .data(s_data), .sclk(shift_clk),
    .busy(s_busy));

  assign f_done = a_done | s_done;
  assign f_data = is_shift ? s_data : a_data;
  assign f_b9   = is_shift ? 1'b0 : a_b9;

  rx_holding #(.DW(DW)) i_hold (
    .clk(clk), .rst_n(rst_n), .frame_done(f_done), .frame_data(f_data),
    .frame_b9(f_b9), .mode(mode), .mp_en(mp_en), .clr(done_clr),
    .hold_data(rx_byte), .hold_b9(rx_bit9), .flag(rx_done));

  p_m0_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_busy) |-> ($past(!rx_done) && $past(rx_en)));
  p_async_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_busy) |-> $past(rx_en));
endmodule

// File: tb/test_serial_rx_filtered.sv
module test_serial_rx_filtered;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, mp_en = 1'b0, done_clr = 1'b0;
  logic [1:0] mode = 2'd1;
  logic os_tick = 1'b0, m0_tick = 1'b0, rxd = 1'b1;
  logic shift_clk, rx_bit9, rx_done;
  logic [7:0] rx_byte;
  int checks = 0, errors = 0, cyc = 0;

  serial_rx_filtered i_serial_rx_filtered (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode(mode), .mp_en(mp_en),
    .done_clr(done_clr), .os_tick(os_tick), .m0_tick(m0_tick), .rxd(rxd),
    .shift_clk(shift_clk), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
    .rx_done(rx_done));

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      cyc = cyc + 1;
      os_tick = (cyc % 2 == 0);
      m0_tick = (cyc % 8 == 0);
    end
  end

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  // one asynchronous frame plus an idle bit; optional clear pulse and mid-bit spikes
  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stp,
                            input logic nine, input logic spike, input int clr_at,
                            output int rise_at);
    int nb;
    logic prev, lvl;
    nb = nine ? 11 : 10;
    rise_at = -1;
    forever begin @(posedge clk); if (os_tick) break; end
    prev = rx_done;
    for (int n = 0; n < (nb + 1) * BITC; n++) begin
      int b, off;
      @(negedge clk);
      if (rx_done && !prev && rise_at < 0) rise_at = n;
      prev = rx_done;
      b = n / BITC;
      off = n % BITC;
      if (b == 0) lvl = 1'b0;
      else if (b <= 8) lvl = d[b-1];
      else if (nine && b == 9) lvl = b9;
      else if (b == nb - 1) lvl = stp;
      else lvl = 1'b1;
      if (spike && b >= 1 && b <= 5 && (off / 2) == (b + 4)) lvl = ~lvl;
      rxd = lvl;
      done_clr = (n == clr_at);
    end
    rxd = 1'b1;
    done_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 flag", {8'd0, rx_done}, 9'd0);
    check("R1 byte", {1'b0, rx_byte}, 9'd0);
    check("R1 bit9", {8'd0, rx_bit9}, 9'd0);
    check("R1 sclk", {8'd0, shift_clk}, 9'd1);
  endtask

  task automatic t_mode1();
    int r;
    mode = 2'd1; mp_en = 1'b0; rx_en = 1'b1;
    send_frame(8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, -1, r);
    check("R4 byte", {1'b0, rx_byte}, 9'h0A5);
    check("R5 stop to bit9", {8'd0, rx_bit9}, 9'd1);
    check("R2 flag", {8'd0, rx_done}, 9'd1);
    clear_flag();
    check("R9 clear", {8'd0, rx_done}, 9'd0);
    mp_en = 1'b1;
    send_frame(8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, -1, r);
    check("R5 bad stop filtered", {8'd0, rx_done}, 9'd0);
    check("R7 byte kept", {rx_bit9, rx_byte}, 9'h1A5);
    mp_en = 1'b0;
    send_frame(8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, -1, r);
    check("R5 unfiltered bad stop", {rx_bit9, rx_byte}, 9'h00F);
    check("R5 flag", {8'd0, rx_done}, 9'd1);
    clear_flag();
  endtask

  task automatic t_nine();
    int r;
    mode = 2'd2; mp_en = 1'b0;
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, -1, r);
    check("R6 mode2 data", {rx_bit9, rx_byte}, 9'h03C);
    check("R6 stop ignored", {8'd0, rx_done}, 9'd1);
    clear_flag();
    mode = 2'd3; mp_en = 1'b1;
    send_frame(8'h11, 1'b0, 1'b1, 1'b1, 1'b0, -1, r);
    check("R6 data frame filtered", {8'd0, rx_done}, 9'd0);
    check("R7 suppressed keeps", {rx_bit9, rx_byte}, 9'h03C);
    send_frame(8'h42, 1'b1, 1'b1, 1'b1, 1'b0, -1, r);
    check("R6 address frame", {rx_bit9, rx_byte}, 9'h142);
    check("R6 address flag", {8'd0, rx_done}, 9'd1);
    mp_en = 1'b0;
    send_frame(8'h99, 1'b0, 1'b1, 1'b1, 1'b0, -1, r);
    check("R8 overrun keeps", {rx_bit9, rx_byte}, 9'h142);
    check("R8 flag", {8'd0, rx_done}, 9'd1);
    clear_flag();
  endtask

  task automatic t_enable_glitch();
    int r;
    mode = 2'd1; rx_en = 1'b0;
    send_frame(8'h77, 1'b0, 1'b1, 1'b0, 1'b0, -1, r);
    check("R2 disabled", {rx_bit9, rx_done, rx_byte}, {1'b1, 1'b0, 8'h42});
    rx_en = 1'b1;
    @(negedge clk); rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    check("R3 start glitch", {8'd0, rx_done}, 9'd0);
    send_frame(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, -1, r);
    check("R3 after glitch", {rx_done, rx_byte}, 9'h15A);
    clear_flag();
    send_frame(8'h00, 1'b0, 1'b1, 1'b0, 1'b1, -1, r);
    check("R3 vote high spikes", {rx_done, rx_byte}, 9'h100);
    clear_flag();
    send_frame(8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, -1, r);
    check("R3 vote low spikes", {rx_done, rx_byte}, 9'h1FF);
    clear_flag();
  endtask

  task automatic t_same_cycle();
    int k, r;
    mode = 2'd1; mp_en = 1'b0;
    send_frame(8'h21, 1'b0, 1'b1, 1'b0, 1'b0, -1, k);
    check("R9 reference frame", {rx_done, rx_byte}, 9'h121);
    send_frame(8'h84, 1'b0, 1'b1, 1'b0, 1'b0, k - 1, r);
    check("R9 clear with completion", {rx_done, rx_byte}, 9'h184);
    mode = 2'd3;
    send_frame(8'h6E, 1'b1, 1'b1, 1'b1, 1'b0, 5 * BITC, r);
    check("R11 cleared mid frame", {rx_done, rx_byte}, 9'h16E);
    check("R11 bit9", {8'd0, rx_bit9}, 9'd1);
  endtask

  task automatic t_shift_mode();
    logic [7:0] d;
    int lows;
    d = 8'hC3;
    mode = 2'd0; mp_en = 1'b1; lows = 0;
    repeat (100) begin @(negedge clk); if (!shift_clk) lows++; end
    check("R10 no start while flag", lows[8:0], 9'd0);
    clear_flag();
    for (int i = 0; i < 8; i++) begin
      @(negedge shift_clk);
      #1 rxd = d[i];
    end
    repeat (40) @(negedge clk);
    check("R10 shift byte", {rx_bit9, rx_byte}, 9'h0C3);
    check("R10 flag", {7'd0, shift_clk, rx_done}, 9'd3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_mode1();
    t_nine();
    t_enable_glitch();
    t_same_cycle();
    t_shift_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule